// File: doc/BRIEF.md
# Switching Clock Source Auto-Selector

This block decides when each switching cycle of a buck converter begins. A free-running internal oscillator delivers a one-cycle strobe at the nominal switching rate (about 750 kHz). An optional external clock arrives on an asynchronous sync pin. The block runs in the fast system clock domain. It emits a single-cycle `cycle_start` pulse for every switching period, and a flag that shows whether the external source is the one in use.

No configuration is needed. The first rising edge seen on the sync pin takes over cycle timing. The block stays on the external source while edges keep coming. When no edge has been detected for four nominal internal periods, it returns to the internal strobe. Spacing rules apply in both modes. A start closer than `MIN_GAP` system clocks to the previous one is deferred or dropped. A period longer than `MAX_GAP` is closed by an inserted start. So switching never stops and never produces a runt cycle, whichever source is active or changing.

Top module: `sws_clk_select`

## Requirements
- R1: While reset is asserted, and immediately after it is released, `cycle_start` and `ext_active` are both 0.
- R2: In internal mode, an `int_tick` pulse gives a `cycle_start` pulse one clock later, but only when at least `MIN_GAP` (default 9) clocks have passed since the previous start. A tick that comes earlier is dropped.
- R3: A rising edge on `sync_pin` passes through two synchronizer flops and an edge detector. When spacing allows, `cycle_start` and `ext_active` both go high on the third rising clock edge after the pin rises.
- R4: While `ext_active` is 1, `int_tick` has no effect on `cycle_start`.
- R5: Only rising edges on `sync_pin` count. A falling edge produces no start and does not change `ext_active`.
- R6: An external edge detected fewer than `MIN_GAP` clocks after the previous start still sets `ext_active` at once. Its start is deferred until exactly `MIN_GAP` clocks after that previous start.
- R7: In either mode, if no start has been produced for `MAX_GAP` (default 18) clocks, a start is inserted, so no period exceeds `MAX_GAP`.
- R8: `ext_active` returns to 0 exactly `4*SYS_PER_INT` (default 48) clocks after the last detected external edge. From that point `int_tick` again produces starts.
- R9: An external edge detected in the same cycle as the timeout expires restarts the timeout. `ext_active` stays 1.
- R10: `cycle_start` is never high for two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| int_tick | input | 1 | One-clock strobe from the internal oscillator, once per nominal period |
| sync_pin | input | 1 | Asynchronous external clock input; only rising edges are used |
| cycle_start | output | 1 | One-clock pulse marking the start of a switching cycle |
| ext_active | output | 1 | 1 while switching follows the external clock |

## Verification
Two functions can fall in the same cycle: a new external edge being detected, and the four-period timeout expiring. The bench provokes this by raising the pin so that the edge detector fires on the very cycle the timeout counter reaches its limit. It then checks that `ext_active` holds and that a start follows on the next clock. The same timeline without the edge serves as the contrast case, where the flag drops at that edge. A second overlap is an edge that arrives inside the minimum spacing window while an internal tick is also present. Here the bench checks that the deferred external start lands exactly `MIN_GAP` clocks after the previous start and that the tick leaves no trace.

// File: rtl/sws_pkg.sv
package sws_pkg;
  // source currently timing the switching cycles
  typedef enum logic {
    SRC_INTERNAL = 1'b0,
    SRC_EXTERNAL = 1'b1
  } src_e;
endpackage

// File: rtl/sws_sync_edge.sv
module sws_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic rise
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              last_q;

  // synchronizer chain, one flop per stage
  assign chain_d[0] = pin_async;
  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
      assign chain_d[g] = chain_q[g-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign rise = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/sws_gap_timer.sv
module sws_gap_timer #(
  parameter int MIN_GAP = 9,
  parameter int MAX_GAP = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic gap_ok,
  output logic gap_full
);
  localparam int W = $clog2(MAX_GAP + 1);
  localparam logic [W-1:0] OK_AT   = W'(MIN_GAP - 1);
  localparam logic [W-1:0] FULL_AT = W'(MAX_GAP - 1);
  localparam logic [W-1:0] SAT_AT  = W'(MAX_GAP);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  // counts clocks elapsed since the last emitted start
  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (start) begin
      cnt_d = '0;
    end else if (cnt_q != SAT_AT) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_en = 1'b0;
    end
  end

  // reset value lets the first start pass without forcing a filler
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= OK_AT;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign gap_ok   = (cnt_q >= OK_AT);
  assign gap_full = (cnt_q >= FULL_AT);
endmodule

// File: rtl/sws_lock_ctl.sv
module sws_lock_ctl
  import sws_pkg::*;
#(
  parameter int TMO_CYC = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  output logic ext_on
);
  localparam int W = $clog2(TMO_CYC + 1);
  localparam logic [W-1:0] LAST = W'(TMO_CYC - 1);

  src_e         src_q, src_d;
  logic [W-1:0] tmo_q, tmo_d;
  logic         reg_en;

  always_comb begin
    src_d  = src_q;
    tmo_d  = tmo_q;
    reg_en = 1'b0;
    if (rise) begin
      // a fresh edge locks (or keeps) the external source and restarts the window
      src_d  = SRC_EXTERNAL;
      tmo_d  = '0;
      reg_en = 1'b1;
    end else if (src_q == SRC_EXTERNAL) begin
      reg_en = 1'b1;
      if (tmo_q >= LAST) begin
        src_d = SRC_INTERNAL;
        tmo_d = '0;
      end else begin
        tmo_d = tmo_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= SRC_INTERNAL;
      tmo_q <= '0;
    end else if (reg_en) begin
      src_q <= src_d;
      tmo_q <= tmo_d;
    end
  end

  assign ext_on = (src_q == SRC_EXTERNAL);
endmodule

// File: rtl/sws_clk_select.sv
module sws_clk_select #(
  parameter int SYS_PER_INT = 12,
  parameter int TMO_PERIODS = 4,
  parameter int MIN_GAP     = 9,
  parameter int MAX_GAP     = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic int_tick,
  input  logic sync_pin,
  output logic cycle_start,
  output logic ext_active
);
  localparam int TMO_CYC = TMO_PERIODS * SYS_PER_INT;

  logic edge_rise;
  logic gap_ok, gap_full;
  logic want_ext, fire_ext, fire_int, fire_fill;
  logic start_d, start_q;
  logic pend_d, pend_q;

  sws_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (sync_pin),
    .rise      (edge_rise)
  );

  sws_gap_timer #(.MIN_GAP(MIN_GAP), .MAX_GAP(MAX_GAP)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_d),
    .gap_ok   (gap_ok),
    .gap_full (gap_full)
  );

  sws_lock_ctl #(.TMO_CYC(TMO_CYC)) u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .rise   (edge_rise),
    .ext_on (ext_active)
  );

  // start arbitration: external edge (new or deferred) first, then
  // the internal strobe, then the period cap
  always_comb begin
    want_ext  = edge_rise | pend_q;
    fire_ext  = want_ext & gap_ok;
    fire_int  = ~ext_active & ~want_ext & int_tick & gap_ok;
    fire_fill = ~want_ext & gap_full;
    start_d   = fire_ext | fire_int | fire_fill;
    pend_d    = want_ext & ~gap_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      start_q <= start_d;
      pend_q  <= pend_d;
    end
  end

  assign cycle_start = start_q;
endmodule

// File: rtl/sws_clk_select_chk.sv
module sws_clk_select_chk #(
  parameter int MIN_GAP = 9,
  parameter int MAX_GAP = 18
) (
  input logic clk,
  input logic rst_n,
  input logic cycle_start,
  input logic ext_active,
  input logic rise
);
  localparam int W = $clog2(MAX_GAP + 2);
  localparam logic [W-1:0] SAT = W'(MAX_GAP + 1);

  logic [W-1:0] since_q;
  logic         seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else if (cycle_start) begin
      since_q <= W'(1);
      seen_q  <= 1'b1;
    end else if (since_q != SAT) begin
      since_q <= since_q + 1'b1;
    end
  end

  // R6
  min_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && cycle_start) |-> (since_q >= W'(MIN_GAP)));

  // R7
  max_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> (since_q <= W'(MAX_GAP)));

  // R3
  lock_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> ext_active);

  // R9
  no_drop_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_active) |-> !$past(rise));

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |=> !cycle_start);
endmodule

bind sws_clk_select sws_clk_select_chk #(.MIN_GAP(MIN_GAP), .MAX_GAP(MAX_GAP)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cycle_start (cycle_start),
  .ext_active  (ext_active),
  .rise        (edge_rise)
);

// File: tb/sws_clk_select_test.sv
module sws_clk_select_test;
  logic clk = 1'b0;
  logic rst_n;
  logic int_tick;
  logic sync_pin;
  logic cycle_start;
  logic ext_active;

  int n_checks = 0;
  int n_fail   = 0;
  logic prev_start;

  always #5 clk = ~clk;

  sws_clk_select uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .int_tick    (int_tick),
    .sync_pin    (sync_pin),
    .cycle_start (cycle_start),
    .ext_active  (ext_active)
  );

  // {sync_pin, int_tick, expected cycle_start, expected ext_active}
  localparam logic [3:0] VEC [24] = '{
    4'b0110, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0100,
    4'b0000, 4'b0000, 4'b0000, 4'b0110, 4'b1000, 4'b1000,
    4'b1001, 4'b0101, 4'b0001, 4'b0001, 4'b0001, 4'b0001,
    4'b0011, 4'b0001, 4'b0001, 4'b0001, 4'b0001, 4'b0001
  };

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // drive inputs, let one rising edge pass, sample 2 ns after it
  task automatic step(input logic s, input logic t);
    sync_pin = s;
    int_tick = t;
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    rst_n    = 1'b0;
    sync_pin = 1'b0;
    int_tick = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R1 start in reset", cycle_start, 1'b0);
    check("R1 ext in reset", ext_active, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic watch_pulse();
    if (prev_start && cycle_start) begin
      n_fail++;
      $display("FAIL R10: actual 1 expected 0 (two-cycle pulse) at %0t", $time);
    end
    prev_start = cycle_start;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    prev_start = 1'b0;
    do_reset();
    #1;
    check("R1 start after release", cycle_start, 1'b0);
    check("R1 ext after release", ext_active, 1'b0);
    #1;

    // table: R2 tick latency and drop, R3 lock, R6 deferral, R5 falling edge, R4 ignore
    for (int i = 0; i < 24; i++) begin
      step(VEC[i][3], VEC[i][2]);
      check($sformatf("R2/R3/R5/R6 vec %0d start", i), cycle_start, VEC[i][1]);
      check($sformatf("R3/R4 vec %0d ext", i), ext_active, VEC[i][0]);
      watch_pulse();
    end

    // fall-back: R4 ticks ignored, R7 fillers, R8 timeout then ticks resume
    do_reset();
    prev_start = 1'b0;
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    check("R3 lock start", cycle_start, 1'b1);
    check("R3 lock ext", ext_active, 1'b1);
    for (int k = 3; k <= 60; k++) begin
      step((k < 5) ? 1'b1 : 1'b0, 1'b1);
      check($sformatf("R4/R7/R8 step %0d start", k), cycle_start,
            (k == 20 || k == 38 || k == 51 || k == 60) ? 1'b1 : 1'b0);
      check($sformatf("R8 step %0d ext", k), ext_active, (k < 50) ? 1'b1 : 1'b0);
      watch_pulse();
    end

    // R9: edge detected in the very cycle the timeout expires
    do_reset();
    prev_start = 1'b0;
    for (int k = 0; k <= 60; k++) begin
      step((k < 10 || k >= 48) ? 1'b1 : 1'b0, 1'b0);
      if (k >= 2) begin
        check($sformatf("R9 step %0d start", k), cycle_start,
              (k == 2 || k == 20 || k == 38 || k == 50) ? 1'b1 : 1'b0);
        check($sformatf("R9 step %0d ext", k), ext_active, 1'b1);
      end
      watch_pulse();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule